// File: doc/BRIEF.md
# Conditional Deserialising Input Port

This block gathers narrow pin samples into a processor-sized word. On every port-clock edge (a one-cycle `tick` pulse on the system clock) it may take a sample of `PIN_W` pins and shift it into a packing register. The first sample of a word lands in the lowest bits and the newest in the highest bits. Once `WORD_W / PIN_W` samples are held, the whole word moves into a transfer register. The processor drains that register over a valid/ready pair, and a 16-bit count of port-clock edges, taken at the moment of the move, comes with each word.

Software starts a capture with a one-cycle `arm` pulse. The pulse can carry a start time, and the port then ignores the pins until its edge counter reaches that value. It can also carry a pin condition (equal or not equal to a programmed value). Under a condition, samples are thrown away until one matches. The matching sample becomes the first one kept, and the condition then switches itself off. When both a time and a condition are given, the time is met first. Four strobe modes decide which edges count and whether a ready-out line tells the sender that the port has room. `arm` also empties any partly packed word.

Top module: `cond_deser_port`

## Requirements
- R1: Samples pack from the least significant end: with `PIN_W`=4 and `WORD_W`=8, the first kept sample appears in `rd_data[3:0]` and the second in `rd_data[7:4]`.
- R2: The cycle after the tick that completes a word, with the transfer register empty, `rd_valid` is 1 and `rd_data` holds that word. The packing register starts the next word from empty.
- R3: Once raised, `rd_valid` and `rd_data` stay unchanged until a cycle with `rd_valid` and `rd_ready` both high. After such a cycle `rd_valid` is 0 unless another word moved in that same cycle.
- R4: The edge counter starts at 0 after reset and adds one on every `tick`. `rd_stamp` shows the counter value of the cycle in which the word moved into the transfer register.
- R5: `strobe_mode` values are 0 implicit, 1 master, 2 slave, 3 both. In modes 2 and 3 a tick with `rdy_in` low takes no sample.
- R6: In modes 1 and 3, `rdy_out` is high while capturing with room in the packing register. It is low when that register holds a full word waiting for the transfer register. In modes 0 and 2, `rdy_out` is always 0.
- R7: When the transfer register is occupied and the packing register holds a full word, further samples are dropped. The held word moves across in the same cycle the transfer register is read.
- R8: After an `arm` with `arm_timed`=1, ticks taken while the counter is below `arm_time` are discarded and `rdy_out` is low. The tick at which the counter equals `arm_time` is the first one eligible.
- R9: `arm_cond` encoding: 0 none, 1 pins equal `arm_value`, 2 pins not equal `arm_value`. While the condition is pending, non-matching samples are discarded and `rdy_out` (modes 1 and 3) is high.
- R10: The sample that satisfies the condition is kept as the first sample of the word. The condition is then cleared, so the next samples are kept whatever their value.
- R11: With both a time and a condition armed, samples that would match the condition but arrive before the target count are discarded. The condition is evaluated from the target tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse marking a port-clock edge |
| pins | input | PIN_W | Pin values sampled on a tick |
| rdy_in | input | 1 | Incoming strobe, honoured in modes 2 and 3 |
| strobe_mode | input | 2 | 0 implicit, 1 master, 2 slave, 3 both |
| arm | input | 1 | One-cycle pulse that loads a new start setup |
| arm_timed | input | 1 | Wait for the edge counter to reach `arm_time` |
| arm_time | input | CNT_W | Target counter value |
| arm_cond | input | 2 | 0 none, 1 equal, 2 not equal |
| arm_value | input | PIN_W | Value compared against the pins |
| rd_valid | output | 1 | Transfer register holds a word |
| rd_ready | input | 1 | Processor takes the word |
| rd_data | output | WORD_W | Packed word |
| rd_stamp | output | CNT_W | Counter value when the word moved |
| rdy_out | output | 1 | Outgoing strobe, driven in modes 1 and 3 |

## Verification
In one cycle, a processor read of the transfer register can coincide with the packing register handing over a full word. The bench sets this up in master mode. It fills the transfer register, then packs a second word that has to wait, and drops an extra sample on the way. It then reads once. It expects `rd_valid` to stay high with the waiting word in place, `rd_stamp` equal to the counter at the read, and the next word to start cleanly after the dropped sample.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_TIME = 2'd1,
        PH_COND = 2'd2
    } phase_e;

    localparam logic [1:0] COND_NONE = 2'd0;
    localparam logic [1:0] COND_EQ   = 2'd1;
    localparam logic [1:0] COND_NE   = 2'd2;

    localparam logic [1:0] MODE_IMPL  = 2'd0;
    localparam logic [1:0] MODE_MAST  = 2'd1;
    localparam logic [1:0] MODE_SLAV  = 2'd2;
    localparam logic [1:0] MODE_BOTH  = 2'd3;
endpackage

// File: rtl/cdp_strobe_gate.sv
module cdp_strobe_gate
    import cdp_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       tick,
    input  logic       rdy_in,
    output logic       take
);
    logic needs_in;

    always_comb begin
        needs_in = (mode == MODE_SLAV) || (mode == MODE_BOTH);
        take     = tick && (!needs_in || rdy_in);
    end
endmodule

// File: rtl/cdp_cond_cmp.sv
module cdp_cond_cmp
    import cdp_pkg::*;
#(
    parameter int PIN_W = 4
) (
    input  logic [1:0]       cond,
    input  logic [PIN_W-1:0] pins,
    input  logic [PIN_W-1:0] value,
    output logic             hit
);
    always_comb begin
        unique case (cond)
            COND_EQ: hit = (pins == value);
            COND_NE: hit = (pins != value);
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/cond_deser_port.sv
module cond_deser_port
    import cdp_pkg::*;
#(
    parameter int PIN_W  = 4,
    parameter int WORD_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [PIN_W-1:0]  pins,
    input  logic              rdy_in,
    input  logic [1:0]        strobe_mode,
    input  logic              arm,
    input  logic              arm_timed,
    input  logic [CNT_W-1:0]  arm_time,
    input  logic [1:0]        arm_cond,
    input  logic [PIN_W-1:0]  arm_value,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_stamp,
    output logic              rdy_out
);
    localparam int SLOTS  = WORD_W / PIN_W;
    localparam int FILL_W = $clog2(SLOTS + 1);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(SLOTS);

    typedef struct packed {
        phase_e             phase;
        logic [1:0]         cond;
        logic [PIN_W-1:0]   value;
        logic [CNT_W-1:0]   target;
        logic [CNT_W-1:0]   cnt;
        logic [WORD_W-1:0]  sh;
        logic [FILL_W-1:0]  fill;
        logic [WORD_W-1:0]  xfer;
        logic               xfer_v;
        logic [CNT_W-1:0]   stamp;
    } st_t;

    st_t st_d, st_q;

    logic   take;
    logic   hit;
    logic   pop;
    logic   keep;
    phase_e ph_eff;
    logic [FILL_W-1:0] fill_obs;

    cdp_strobe_gate u_gate (
        .mode   (strobe_mode),
        .tick   (tick),
        .rdy_in (rdy_in),
        .take   (take)
    );

    cdp_cond_cmp #(.PIN_W(PIN_W)) u_cmp (
        .cond  (st_q.cond),
        .pins  (pins),
        .value (st_q.value),
        .hit   (hit)
    );

    always_comb begin
        st_d   = st_q;
        keep   = 1'b0;
        pop    = st_q.xfer_v && rd_ready;
        ph_eff = st_q.phase;

        if (tick) st_d.cnt = st_q.cnt + 1'b1;
        if (pop)  st_d.xfer_v = 1'b0;

        if (arm) begin
            st_d.sh     = '0;
            st_d.fill   = '0;
            st_d.cond   = arm_cond;
            st_d.value  = arm_value;
            st_d.target = arm_time;
            if (arm_timed)                  st_d.phase = PH_TIME;
            else if (arm_cond != COND_NONE) st_d.phase = PH_COND;
            else                            st_d.phase = PH_RUN;
        end else begin
            // Time is judged on every edge, gated or not, so it is never missed
            if (st_q.phase == PH_TIME && tick && st_q.cnt == st_q.target)
                ph_eff = (st_q.cond != COND_NONE) ? PH_COND : PH_RUN;
            st_d.phase = ph_eff;
            if (take) begin
                if (ph_eff == PH_RUN) begin
                    keep = 1'b1;
                end else if (ph_eff == PH_COND && hit) begin
                    keep       = 1'b1;
                    st_d.phase = PH_RUN;
                    st_d.cond  = COND_NONE;
                end
            end
            if (keep && st_q.fill < FULL) begin
                st_d.sh = st_q.sh >> PIN_W;
                st_d.sh[WORD_W-1 -: PIN_W] = pins;
                st_d.fill = st_q.fill + 1'b1;
            end
        end

        if (st_d.fill == FULL && (!st_q.xfer_v || pop)) begin
            st_d.xfer   = st_d.sh;
            st_d.xfer_v = 1'b1;
            st_d.stamp  = st_q.cnt;
            st_d.sh     = '0;
            st_d.fill   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_valid = st_q.xfer_v;
        rd_data  = st_q.xfer;
        rd_stamp = st_q.stamp;
        fill_obs = st_q.fill;
        if (!strobe_mode[0])             rdy_out = 1'b0;
        else if (st_q.phase == PH_TIME)  rdy_out = 1'b0;
        else if (st_q.phase == PH_COND)  rdy_out = 1'b1;
        else                             rdy_out = (st_q.fill < FULL);
    end
endmodule

// File: rtl/cdp_chk.sv
module cdp_chk #(
    parameter int WORD_W = 8,
    parameter int CNT_W  = 16,
    parameter int FILL_W = 2,
    parameter int SLOTS  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              rdy_in,
    input logic [1:0]        strobe_mode,
    input logic              arm,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [WORD_W-1:0] rd_data,
    input logic [CNT_W-1:0]  rd_stamp,
    input logic              rdy_out,
    input logic [FILL_W-1:0] fill
);
    logic [CNT_W-1:0] edges_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    edges_q <= '0;
        else if (tick) edges_q <= edges_q + 1'b1;
    end

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_stamp)));

    // R4
    stamp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (rd_stamp == $past(edges_q)));

    // R5
    gated_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_mode[1] && !rdy_in && !rd_valid && !arm) |=> $stable(fill));

    // R6
    full_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_mode[0] && fill == FILL_W'(SLOTS)) |-> !rdy_out);

    // R7
    held_needs_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FILL_W'(SLOTS)) |-> rd_valid);
endmodule

bind cond_deser_port cdp_chk #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W),
    .FILL_W (FILL_W),
    .SLOTS  (SLOTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .rdy_in      (rdy_in),
    .strobe_mode (strobe_mode),
    .arm         (arm),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_data     (rd_data),
    .rd_stamp    (rd_stamp),
    .rdy_out     (rdy_out),
    .fill        (fill_obs)
);

// File: tb/cond_deser_port_bench.sv
`timescale 1ns/100ps
module cond_deser_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  pins = '0;
    logic        rdy_in = 1'b0;
    logic [1:0]  strobe_mode = 2'd0;
    logic        arm = 1'b0;
    logic        arm_timed = 1'b0;
    logic [15:0] arm_time = '0;
    logic [1:0]  arm_cond = '0;
    logic [3:0]  arm_value = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] rd_stamp;
    logic        rdy_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] tcnt = '0;
    logic [15:0] s;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cond_deser_port u_cond_deser_port (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pins(pins), .rdy_in(rdy_in),
        .strobe_mode(strobe_mode), .arm(arm), .arm_timed(arm_timed),
        .arm_time(arm_time), .arm_cond(arm_cond), .arm_value(arm_value),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_stamp(rd_stamp), .rdy_out(rdy_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit t, input logic [3:0] p, input bit r);
        tick = t; pins = p; rdy_in = r;
        @(posedge clk); #1;
        tick = 1'b0;
        if (t) tcnt = tcnt + 1'b1;
    endtask

    task automatic do_arm(input bit timed, input logic [15:0] at,
                          input logic [1:0] c, input logic [3:0] v);
        arm = 1'b1; arm_timed = timed; arm_time = at; arm_cond = c; arm_value = v;
        @(posedge clk); #1;
        arm = 1'b0;
    endtask

    task automatic do_read();
        rd_ready = 1'b1;
        @(posedge clk); #1;
        rd_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk(rd_valid == 1'b0, "R2 reset valid", rd_valid, 0);
        chk(rdy_out == 1'b0, "R6 reset rdy_out", rdy_out, 0);
        chk(rd_stamp == 16'h0, "R4 reset stamp", rd_stamp, 0);
    endtask

    task automatic t_implicit();
        strobe_mode = 2'd0;
        do_arm(1'b0, 16'h0, 2'd0, 4'h0);
        cyc(1'b1, 4'h1, 1'b0);
        chk(rd_valid == 1'b0, "R2 half word not valid", rd_valid, 0);
        s = tcnt;
        cyc(1'b1, 4'h2, 1'b0);
        chk(rd_valid == 1'b1, "R2 word valid", rd_valid, 1);
        chk(rd_data == 8'h21, "R1 lsb first packing", rd_data, 8'h21);
        chk(rd_stamp == s, "R4 stamp", rd_stamp, s);
        chk(rdy_out == 1'b0, "R6 implicit rdy_out", rdy_out, 0);
        cyc(1'b0, 4'h0, 1'b0);
        cyc(1'b0, 4'h0, 1'b0);
        chk(rd_valid == 1'b1 && rd_data == 8'h21, "R3 word held", rd_data, 8'h21);
        do_read();
        chk(rd_valid == 1'b0, "R3 cleared by read", rd_valid, 0);
    endtask

    task automatic t_slave();
        strobe_mode = 2'd2;
        do_arm(1'b0, 16'h0, 2'd0, 4'h0);
        cyc(1'b1, 4'h5, 1'b0);
        cyc(1'b1, 4'h3, 1'b1);
        cyc(1'b1, 4'h7, 1'b0);
        cyc(1'b1, 4'h9, 1'b1);
        chk(rd_valid == 1'b1 && rd_data == 8'h93, "R5 slave gating", rd_data, 8'h93);
        chk(rdy_out == 1'b0, "R6 slave rdy_out", rdy_out, 0);
        do_read();
    endtask

    task automatic t_master_full();
        strobe_mode = 2'd1;
        do_arm(1'b0, 16'h0, 2'd0, 4'h0);
        chk(rdy_out == 1'b1, "R6 master room", rdy_out, 1);
        cyc(1'b1, 4'hA, 1'b0);
        cyc(1'b1, 4'hB, 1'b0);
        cyc(1'b1, 4'hC, 1'b0);
        chk(rdy_out == 1'b1, "R6 master partial room", rdy_out, 1);
        cyc(1'b1, 4'hD, 1'b0);
        chk(rdy_out == 1'b0, "R6 master both full", rdy_out, 0);
        cyc(1'b1, 4'hE, 1'b0);
        chk(rd_data == 8'hBA, "R7 first word intact", rd_data, 8'hBA);
        s = tcnt;
        do_read();
        chk(rd_valid == 1'b1 && rd_data == 8'hDC, "R7 held word moves on read", rd_data, 8'hDC);
        chk(rd_stamp == s, "R4 stamp at late move", rd_stamp, s);
        chk(rdy_out == 1'b1, "R6 room after move", rdy_out, 1);
        do_read();
        cyc(1'b1, 4'hF, 1'b0);
        cyc(1'b1, 4'h1, 1'b0);
        chk(rd_data == 8'h1F, "R7 overflow sample dropped", rd_data, 8'h1F);
        do_read();
    endtask

    task automatic t_timed();
        strobe_mode = 2'd1;
        do_arm(1'b1, tcnt + 16'd2, 2'd0, 4'h0);
        chk(rdy_out == 1'b0, "R8 rdy_out low while timed", rdy_out, 0);
        cyc(1'b1, 4'h4, 1'b0);
        cyc(1'b1, 4'h5, 1'b0);
        chk(rdy_out == 1'b0, "R8 still waiting", rdy_out, 0);
        cyc(1'b1, 4'h6, 1'b0);
        chk(rdy_out == 1'b1, "R8 running after target", rdy_out, 1);
        cyc(1'b1, 4'h7, 1'b0);
        chk(rd_valid == 1'b1 && rd_data == 8'h76, "R8 target tick first", rd_data, 8'h76);
        do_read();
    endtask

    task automatic t_cond_eq();
        strobe_mode = 2'd1;
        do_arm(1'b0, 16'h0, 2'd1, 4'hA);
        chk(rdy_out == 1'b1, "R9 rdy_out high on condition", rdy_out, 1);
        cyc(1'b1, 4'h3, 1'b0);
        cyc(1'b1, 4'hB, 1'b0);
        chk(rdy_out == 1'b1, "R9 still high while no match", rdy_out, 1);
        cyc(1'b1, 4'hA, 1'b0);
        cyc(1'b1, 4'h3, 1'b0);
        chk(rd_valid == 1'b1 && rd_data == 8'h3A, "R10 match kept then free", rd_data, 8'h3A);
        do_read();
    endtask

    task automatic t_cond_ne();
        strobe_mode = 2'd0;
        do_arm(1'b0, 16'h0, 2'd2, 4'h0);
        cyc(1'b1, 4'h0, 1'b0);
        cyc(1'b1, 4'h0, 1'b0);
        cyc(1'b1, 4'h5, 1'b0);
        cyc(1'b1, 4'h0, 1'b0);
        chk(rd_valid == 1'b1 && rd_data == 8'h05, "R9 not-equal condition", rd_data, 8'h05);
        do_read();
    endtask

    task automatic t_timed_cond();
        strobe_mode = 2'd0;
        do_arm(1'b1, tcnt + 16'd2, 2'd1, 4'h6);
        cyc(1'b1, 4'h6, 1'b0);
        cyc(1'b1, 4'h1, 1'b0);
        cyc(1'b1, 4'h2, 1'b0);
        cyc(1'b1, 4'h6, 1'b0);
        chk(rd_valid == 1'b0, "R11 early match ignored", rd_valid, 0);
        cyc(1'b1, 4'h8, 1'b0);
        chk(rd_valid == 1'b1 && rd_data == 8'h86, "R11 time then condition", rd_data, 8'h86);
        do_read();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_implicit();
        t_slave();
        t_master_full();
        t_timed();
        t_cond_eq();
        t_cond_ne();
        t_timed_cond();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule